// File: doc/BRIEF.md
# Robbed-Bit Signalling Receive Debouncer

This block recovers the per-channel A, B, C and D signalling bits that a T1-style receiver finds in the last bit of each DS0 channel byte in every sixth frame. For each of 24 channels it builds up a signalling sample over a superframe and keeps a reported value. That value is presented on a 4-bit status output one cycle after each channel slot, so a downstream status serialiser can forward it in step with the time slot. A one-cycle change strobe marks the slot in which a channel's reported value is updated.

A run-time control selects between two behaviours. In pass-through mode every completed sample is reported at once. In filtered mode a new value is reported only after it has stayed unchanged for 48 frames, which is 6 ms at 125 µs per frame. Because samples arrive every 1.5 ms or 3 ms, the true change is reported 6 to 9 ms after it happens. An extended-superframe mode takes four distinct bits. A twelve-frame mode takes two bits and repeats them as C and D.

Top module: `rbs_rx_debounce`

## Requirements
- R1: After reset, statusValid and changeStb are low, statusAbcd is 0000, and every channel's reported value, candidate and stability count is cleared.
- R2: The signalling bit is chanByte[0], which is the eighth transmitted bit of the channel. It is used only in frames whose frameIdx is 5, 11, 17 or 23. In all other frames chanByte has no effect on any channel.
- R3: With esfMode=1, the bits from frameIdx 5, 11, 17 and 23 are A, B, C and D. They form the sample {A,B,C,D}, with A on bit 3 of statusAbcd. The sample is complete in the frameIdx 23 slot.
- R4: With esfMode=0, the bits from frameIdx 5 and 17 are A, and the bits from frameIdx 11 and 23 are B. The sample {A,B,A,B} is complete in each frameIdx 11 and 23 slot.
- R5: With bypass=1, a completed sample becomes the channel's reported value in the same slot.
- R6: With bypass=0, a channel's stability count rises by one on each visit to that channel and saturates at 48. The candidate is reported in the first visit where the count equals 48 and the candidate differs from the reported value.
- R7: A completed sample that differs from the channel's candidate replaces the candidate and restarts the count at 0. A value that holds for less than 48 frames is therefore never reported.
- R8: statusValid is high exactly one cycle after each slot with slotValid=1 and chanIdx below 24. In that cycle statusAbcd carries that channel's reported value, including any update made in the slot.
- R9: changeStb is high in that same cycle only when the slot changed the channel's reported value. A report of an unchanged value gives no strobe.
- R10: The state of each channel is updated only in its own slots. Activity on other channels leaves it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | 1 | One-cycle strobe marking a channel slot |
| chanIdx | input | 5 | Channel number of the slot, 0 to 23 |
| frameIdx | input | 5 | Frame number within the 24-frame superframe, 0 to 23 |
| chanByte | input | 8 | Received channel byte; bit 0 is the last transmitted bit |
| esfMode | input | 1 | 1: four-bit signalling, 0: two-bit signalling repeated |
| bypass | input | 1 | 1: report samples unfiltered, 0: debounce |
| statusAbcd | output | 4 | Reported {A,B,C,D} of the channel in the previous slot |
| statusValid | output | 1 | statusAbcd is valid this cycle |
| changeStb | output | 1 | The reported value changed in the previous slot |

## Verification
The stimulus is full superframes on all 24 channels. The data bit in the non-signalling frames toggles, so a decoder that samples outside frames 5, 11, 17 and 23 would corrupt the sample. A value held for one, two and three superframes shows that the report arrives in the exact slot where the count reaches 48, and neither one frame early nor one frame late. A three-millisecond glitch that returns to the old value tells a restarting counter apart from a free-running one. Runs in the twelve-frame mode with C and D set differently from A and B prove the repetition. Pass-through runs, a return from pass-through, and a quiet neighbour channel separate an immediate update, a duplicate strobe and crosstalk between channels.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  localparam int SIG_BITS = 4;

  // Strobes from frame/mode decode to the per-channel datapath.
  typedef struct packed {
    logic       slotOk;    // valid slot for an existing channel
    logic       capEn;     // this frame carries a signalling bit
    logic [1:0] capSel;    // 0=A 1=B 2=C 3=D
    logic       sampleEv;  // the sample is complete in this slot
    logic       d4Mode;    // two-bit signalling, C/D repeat A/B
    logic       bypass;    // report without filtering
  } rbsCtrl_t;

endpackage

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int NUM_CH     = 24,
  parameter int SIG_PERIOD = 6,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int FR_W = $clog2(4 * SIG_PERIOD)
) (
  input  logic            slotValid,
  input  logic [CH_W-1:0] chanIdx,
  input  logic [FR_W-1:0] frameIdx,
  input  logic            esfMode,
  input  logic            bypass,
  output rbsCtrl_t        ctrl
);

  localparam logic [CH_W:0] CH_LIM = (CH_W + 1)'(NUM_CH);

  logic       isSig;
  logic [1:0] sigOrd;

  // Signalling frames are the last frame of each group of SIG_PERIOD frames.
  always_comb begin
    isSig  = 1'b0;
    sigOrd = 2'd0;
    for (int k = 0; k < 4; k++) begin
      if (frameIdx == FR_W'((k + 1) * SIG_PERIOD - 1)) begin
        isSig  = 1'b1;
        sigOrd = 2'(k);
      end
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.slotOk   = slotValid && ({1'b0, chanIdx} < CH_LIM);
    ctrl.d4Mode   = !esfMode;
    ctrl.bypass   = bypass;
    ctrl.capEn    = isSig;
    ctrl.capSel   = esfMode ? sigOrd : {1'b0, sigOrd[0]};
    ctrl.sampleEv = isSig && (esfMode ? (sigOrd == 2'd3) : sigOrd[0]);
  end

endmodule

// File: rtl/rbs_datapath.sv
module rbs_datapath
  import rbs_pkg::*;
#(
  parameter int NUM_CH        = 24,
  parameter int STABLE_FRAMES = 48,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(STABLE_FRAMES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  rbsCtrl_t            ctrl,
  input  logic [CH_W-1:0]     chanIdx,
  input  logic                sigBit,
  output logic [SIG_BITS-1:0] statusAbcd,
  output logic                statusValid,
  output logic                changeStb
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_FRAMES);

  logic [SIG_BITS-1:0] asmArr  [NUM_CH];
  logic [SIG_BITS-1:0] candArr [NUM_CH];
  logic [SIG_BITS-1:0] repArr  [NUM_CH];
  logic [CNT_W-1:0]    cntArr  [NUM_CH];

  logic [CH_W-1:0]     idx;
  logic [SIG_BITS-1:0] curAsm, curCand, curRep, sampleVec;
  logic [SIG_BITS-1:0] nxtAsm, nxtCand, nxtRep;
  logic [CNT_W-1:0]    curCnt, nxtCnt;
  logic                candChg;

  assign idx = ctrl.slotOk ? chanIdx : '0;

  always_comb begin
    curAsm  = asmArr[idx];
    curCand = candArr[idx];
    curRep  = repArr[idx];
    curCnt  = cntArr[idx];

    nxtAsm = curAsm;
    if (ctrl.capEn) begin
      case (ctrl.capSel)
        2'd0:    nxtAsm[3] = sigBit;
        2'd1:    nxtAsm[2] = sigBit;
        2'd2:    nxtAsm[1] = sigBit;
        default: nxtAsm[0] = sigBit;
      endcase
    end

    if (ctrl.d4Mode) sampleVec = {curAsm[3], sigBit, curAsm[3], sigBit};
    else             sampleVec = {curAsm[3], curAsm[2], curAsm[1], sigBit};

    candChg = ctrl.sampleEv && (sampleVec != curCand);
    nxtCand = candChg ? sampleVec : curCand;
    if (candChg)                nxtCnt = '0;
    else if (curCnt >= CNT_MAX) nxtCnt = CNT_MAX;
    else                        nxtCnt = curCnt + 1'b1;

    if (ctrl.bypass)            nxtRep = ctrl.sampleEv ? sampleVec : curRep;
    else if (nxtCnt == CNT_MAX) nxtRep = nxtCand;
    else                        nxtRep = curRep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        asmArr[c]  <= '0;
        candArr[c] <= '0;
        repArr[c]  <= '0;
        cntArr[c]  <= '0;
      end
      statusAbcd  <= '0;
      statusValid <= 1'b0;
      changeStb   <= 1'b0;
    end else begin
      statusValid <= ctrl.slotOk;
      changeStb   <= ctrl.slotOk && (nxtRep != curRep);
      if (ctrl.slotOk) begin
        asmArr[idx]  <= nxtAsm;
        candArr[idx] <= nxtCand;
        repArr[idx]  <= nxtRep;
        cntArr[idx]  <= nxtCnt;
        statusAbcd   <= nxtRep;
      end
    end
  end

  // R6: the stored count never passes the stability limit
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.slotOk |-> (curCnt <= CNT_MAX));

  // R7: a fresh candidate in a debounced slot never reaches the output at once
  p_no_early_report_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.slotOk && !ctrl.bypass && candChg) |=> !changeStb);

endmodule

// File: rtl/rbs_rx_debounce.sv
module rbs_rx_debounce
  import rbs_pkg::*;
#(
  parameter int NUM_CH        = 24,
  parameter int SIG_PERIOD    = 6,
  parameter int STABLE_FRAMES = 48,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int FR_W = $clog2(4 * SIG_PERIOD)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            slotValid,
  input  logic [CH_W-1:0] chanIdx,
  input  logic [FR_W-1:0] frameIdx,
  input  logic [7:0]      chanByte,
  input  logic            esfMode,
  input  logic            bypass,
  output logic [3:0]      statusAbcd,
  output logic            statusValid,
  output logic            changeStb
);

  localparam logic [CH_W:0] CH_LIM = (CH_W + 1)'(NUM_CH);

  rbsCtrl_t ctrl;

  rbs_ctrl #(.NUM_CH(NUM_CH), .SIG_PERIOD(SIG_PERIOD)) ctrl_i (
    .slotValid (slotValid),
    .chanIdx   (chanIdx),
    .frameIdx  (frameIdx),
    .esfMode   (esfMode),
    .bypass    (bypass),
    .ctrl      (ctrl)
  );

  rbs_datapath #(.NUM_CH(NUM_CH), .STABLE_FRAMES(STABLE_FRAMES)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .chanIdx     (chanIdx),
    .sigBit      (chanByte[0]),
    .statusAbcd  (statusAbcd),
    .statusValid (statusValid),
    .changeStb   (changeStb)
  );

  // R8: a slot for a real channel is answered in the next cycle
  p_valid_lag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && ({1'b0, chanIdx} < CH_LIM)) |=> statusValid);

  // R8: no status without a slot in the cycle before
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |=> (!statusValid && !changeStb));

  // R9: a change is only flagged alongside valid status
  p_stb_with_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    changeStb |-> statusValid);

  // R5: unfiltered updates happen only in sample-completing frames
  p_bypass_on_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    (changeStb && $past(bypass)) |->
      ($past(frameIdx) == FR_W'(2 * SIG_PERIOD - 1) ||
       $past(frameIdx) == FR_W'(4 * SIG_PERIOD - 1)));

endmodule

// File: tb/rbs_rx_debounce_tb.sv
module rbs_rx_debounce_tb_top;

  typedef struct packed {
    logic       esf;
    logic       byp;
    logic [4:0] ch;
    logic [3:0] sig;
    logic [1:0] nsf;
    logic [3:0] expStat;
    logic [1:0] expStb;
    logic [4:0] expFr;   // 31 = no strobe
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 5'd5, 4'b1010, 2'd1, 4'b0000, 2'd0, 5'd31},  // R6 one SF
    '{1'b1, 1'b0, 5'd5, 4'b1010, 2'd1, 4'b0000, 2'd0, 5'd31},  // R6 count 24
    '{1'b1, 1'b0, 5'd5, 4'b1010, 2'd1, 4'b1010, 2'd1, 5'd23},  // R3 reported at 48
    '{1'b1, 1'b0, 5'd6, 4'b0000, 2'd1, 4'b0000, 2'd0, 5'd31},  // R10 R2 neighbour quiet
    '{1'b1, 1'b0, 5'd5, 4'b0110, 2'd1, 4'b1010, 2'd0, 5'd31},  // R7 glitch
    '{1'b1, 1'b0, 5'd5, 4'b1010, 2'd1, 4'b1010, 2'd0, 5'd31},  // R7 glitch gone
    '{1'b1, 1'b0, 5'd5, 4'b1010, 2'd2, 4'b1010, 2'd0, 5'd31},  // R9 no repeat strobe
    '{1'b1, 1'b1, 5'd5, 4'b0001, 2'd1, 4'b0001, 2'd1, 5'd23},  // R5 pass-through
    '{1'b1, 1'b0, 5'd5, 4'b0001, 2'd1, 4'b0001, 2'd0, 5'd31},  // R9 back to filter
    '{1'b0, 1'b0, 5'd9, 4'b1011, 2'd1, 4'b0000, 2'd0, 5'd31},  // R4 D4 pending
    '{1'b0, 1'b0, 5'd9, 4'b1011, 2'd1, 4'b0000, 2'd0, 5'd31},  // R6 count 36
    '{1'b0, 1'b0, 5'd9, 4'b1011, 2'd1, 4'b1010, 2'd1, 5'd11},  // R4 C,D repeat A,B
    '{1'b0, 1'b1, 5'd9, 4'b0111, 2'd1, 4'b0101, 2'd1, 5'd11}   // R5 D4 pass-through
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       slotValid;
  logic [4:0] chanIdx;
  logic [4:0] frameIdx;
  logic [7:0] chanByte;
  logic       esfMode;
  logic       bypass;
  logic [3:0] statusAbcd;
  logic       statusValid;
  logic       changeStb;

  int checks = 0;
  int errors = 0;
  int validMiss = 0;
  logic [3:0] txSig   [24];
  logic [3:0] lastStat[24];
  int         stbCnt  [24];
  int         stbFr   [24];
  logic       prevValid;
  int         prevCh, prevF;

  always #5 clk = ~clk;

  rbs_rx_debounce dut_i (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .chanIdx(chanIdx),
    .frameIdx(frameIdx), .chanByte(chanByte), .esfMode(esfMode),
    .bypass(bypass), .statusAbcd(statusAbcd), .statusValid(statusValid),
    .changeStb(changeStb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tagOf(input int i);
    case (i)
      0, 1, 10: return "R6";
      2:        return "R3";
      3:        return "R10";
      4, 5:     return "R7";
      6, 8:     return "R9";
      7, 12:    return "R5";
      default:  return "R4";
    endcase
  endfunction

  function automatic logic sigLsb(input int ch, input int f, input logic esf);
    if (esf) begin
      case (f)
        5:  return txSig[ch][3];
        11: return txSig[ch][2];
        17: return txSig[ch][1];
        23: return txSig[ch][0];
        default: return logic'((ch + f) & 1);
      endcase
    end else begin
      case (f)
        5, 17:  return txSig[ch][3];
        11, 23: return txSig[ch][2];
        default: return logic'((ch + f) & 1);
      endcase
    end
  endfunction

  task automatic observe();
    if (statusValid !== prevValid) validMiss++;
    if (prevValid && statusValid) begin
      lastStat[prevCh] = statusAbcd;
      if (changeStb) begin
        stbCnt[prevCh]++;
        stbFr[prevCh] = prevF;
      end
    end
  endtask

  task automatic runSf(input int nsf);
    for (int s = 0; s < nsf; s++) begin
      for (int f = 0; f < 24; f++) begin
        for (int ch = 0; ch < 24; ch++) begin
          @(negedge clk);
          observe();
          slotValid = 1'b1;
          chanIdx   = 5'(ch);
          frameIdx  = 5'(f);
          chanByte  = {5'(f), 2'(ch), sigLsb(ch, f, esfMode)};
          prevValid = 1'b1;
          prevCh    = ch;
          prevF     = f;
        end
      end
    end
    @(negedge clk);
    observe();
    slotValid = 1'b0;
    prevValid = 1'b0;
    @(negedge clk);
    observe();
  endtask

  task automatic clearStats();
    for (int c = 0; c < 24; c++) begin
      stbCnt[c] = 0;
      stbFr[c]  = 31;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rstN = 1'b0; slotValid = 1'b0; chanIdx = '0; frameIdx = '0;
    chanByte = '0; esfMode = 1'b1; bypass = 1'b0;
    prevValid = 1'b0; prevCh = 0; prevF = 0;
    for (int c = 0; c < 24; c++) begin
      txSig[c] = '0;
      lastStat[c] = '0;
    end
    clearStats();
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check("R1 status in reset", int'(statusAbcd), 0);
    check("R1 valid in reset", int'(statusValid), 0);
    check("R1 strobe in reset", int'(changeStb), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      esfMode = VEC[i].esf;
      bypass  = VEC[i].byp;
      txSig[VEC[i].ch] = VEC[i].sig;
      clearStats();
      runSf(int'(VEC[i].nsf));
      check({tagOf(i), " status"}, int'(lastStat[VEC[i].ch]), int'(VEC[i].expStat));
      check({tagOf(i), " strobes"}, stbCnt[VEC[i].ch], int'(VEC[i].expStb));
      check({tagOf(i), " strobe frame"}, stbFr[VEC[i].ch], int'(VEC[i].expFr));
    end

    // R8: statusValid tracked every slot one cycle later
    check("R8 valid timing mismatches", validMiss, 0);

    // R1: reset mid-run clears stored reported values
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", int'(statusValid), 0);
    check("R1 status after reset", int'(statusAbcd), 0);
    rstN = 1'b1;
    esfMode = 1'b1;
    bypass  = 1'b0;
    for (int c = 0; c < 24; c++) txSig[c] = '0;
    clearStats();
    runSf(1);
    check("R1 ch9 cleared", int'(lastStat[9]), 0);
    check("R1 ch5 cleared", int'(lastStat[5]), 0);
    check("R1 no strobe after reset", stbCnt[9] + stbCnt[5], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule